// File: doc/BRIEF.md
# Register-File ALU Execute Unit

This block executes the register-operand instructions of an 8-bit accumulator machine. These are the arithmetic, logic, move, increment, decrement-and-skip and rotate instructions. Each accepted 13-bit instruction word carries a 7-bit operation code in its upper bits and a 6-bit register number in its lower bits. The unit reads one of 64 addressable registers. The lower 32 addresses are common to all banks. The upper 32 addresses are banked, and bits 7:6 of register 4 choose the bank. The unit combines that operand with the accumulator A. The result goes either to A or back to the register. The zero, carry and half-carry flags are updated as the operation requires.

Subtraction is register minus accumulator, and its carry means "no borrow". Address 3 is the status register. The flags live in its low bits, and an instruction's own flag updates take precedence over a value it writes there. When a decrement-and-skip result is zero, the unit pulses a skip output. It also withholds ready for one cycle, so the following instruction slot is consumed without effect. A skipping instruction therefore costs two cycles, and every other instruction costs one. Instruction fetch sits outside this block and must honour that ready signal.

Top module: `ex_regalu_unit`

## Requirements
- R1: After reset, A is 0, every register reads 0, the flags Z, C and DC are 0, ins_ready is 1 and skip_o is 0.
- R2: An instruction executes in the cycle where ins_valid and ins_ready are both 1. Its code is ins_word[12:6] and its register is ins_word[5:0]. Bit 6 of the word selects the destination: 1 means the register and 0 means A. Codes 0 and 26 to 127 change nothing.
- R3: Codes 4 and 5 compute register minus A. C is 1 when the register is at least A. DC is 1 when the register's low nibble is at least A's low nibble. Z is 1 when the 8-bit result is 0.
- R4: Codes 14 and 15 compute register plus A. C is the carry out of bit 7, DC is the carry out of bit 3, and Z marks a zero result.
- R5: The following operations update only Z, set when the result is 0, and leave C and DC unchanged: code 2 (clear A), code 3 (clear register), 6/7 (decrement), 8/9 (OR), 10/11 (AND), 12/13 (XOR), 16/17 (move register), 18/19 (complement) and 20/21 (increment).
- R6: Code 1 copies A into the register and changes no flag.
- R7: Codes 22 and 23 compute register minus 1 without touching any flag. When the result is 0, skip_o is 1 and ins_ready is 0 in the next cycle, and an instruction offered in that cycle is discarded.
- R8: Codes 24 and 25 rotate right through carry. Bit n moves to bit n-1, the old C enters bit 7 and bit 0 goes to C. Z and DC are unchanged.
- R9: Addresses 0x00 to 0x1F are shared by all banks. Addresses 0x20 to 0x3F are held separately for each of four banks, chosen by bits 7:6 of register 4.
- R10: Address 3 reads and writes the status byte, with C at bit 0, DC at bit 1 and Z at bit 2. When an instruction writes address 3, the flags that instruction updates replace the written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | An instruction word is offered |
| ins_word | input | 13 | Code in [12:6], register number in [5:0] |
| ins_ready | output | 1 | Low during the slot consumed by a skip |
| acc_o | output | 8 | Accumulator A |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / no-borrow flag |
| flag_dc | output | 1 | Half-carry / half no-borrow flag |
| skip_o | output | 1 | High for the cycle of a skipped slot |

## Verification
Registers are reachable only through A, so a wrong bank select or a lost register write shows up at acc_o one cycle after a move-to-A of that address. That is two instructions after the faulty write. A corrupted status byte appears on the flag pins one cycle after the offending instruction. It also shows when address 3 is read back into A. A skip state that sticks or never arms shows at once on ins_ready and skip_o, and it shows as an accumulator change in a slot that should have been discarded.

// File: rtl/ex_pkg.sv
package ex_pkg;

   localparam int FLG_C     = 0;
   localparam int FLG_DC    = 1;
   localparam int FLG_Z     = 2;
   localparam int STAT_ADDR = 3;
   localparam int BANK_ADDR = 4;

   typedef enum logic [3:0] {
      K_NONE, K_MOVRA, K_CLR, K_SUB, K_DEC, K_OR, K_AND, K_XOR,
      K_ADD, K_MOV, K_COM, K_INC, K_DJZ, K_RRC
   } kind_e;

   typedef struct packed {
      logic z;
      logic c;
      logic dc;
   } upd_t;

   // Pairs of codes share one operation; the low code bit picks the destination.
   function automatic kind_e op_kind(input logic [6:0] op);
      case (op[6:1])
         6'd0:    op_kind = op[0] ? K_MOVRA : K_NONE;
         6'd1:    op_kind = K_CLR;
         6'd2:    op_kind = K_SUB;
         6'd3:    op_kind = K_DEC;
         6'd4:    op_kind = K_OR;
         6'd5:    op_kind = K_AND;
         6'd6:    op_kind = K_XOR;
         6'd7:    op_kind = K_ADD;
         6'd8:    op_kind = K_MOV;
         6'd9:    op_kind = K_COM;
         6'd10:   op_kind = K_INC;
         6'd11:   op_kind = K_DJZ;
         6'd12:   op_kind = K_RRC;
         default: op_kind = K_NONE;
      endcase
   endfunction

endpackage

// File: rtl/ex_alu.sv
module ex_alu
   import ex_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] r_val,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              z_out,
   output logic              c_out,
   output logic              dc_out,
   output upd_t              upd,
   output logic              skip_req
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   logic [DATA_W:0] add_w, sub_w;
   logic [4:0]      add_n, sub_n;

   // Subtraction as r + ~a + 1: carry out means "no borrow".
   assign add_w = {1'b0, r_val} + {1'b0, a_val};
   assign sub_w = {1'b0, r_val} + {1'b0, ~a_val} + {{DATA_W{1'b0}}, 1'b1};
   assign add_n = {1'b0, r_val[3:0]} + {1'b0, a_val[3:0]};
   assign sub_n = {1'b0, r_val[3:0]} + {1'b0, ~a_val[3:0]} + 5'd1;

   always_comb begin
      res      = '0;
      c_out    = c_in;
      dc_out   = 1'b0;
      upd      = '0;
      skip_req = 1'b0;
      case (kind)
         K_MOVRA: res = a_val;
         K_CLR:   begin res = '0;              upd.z = 1'b1; end
         K_SUB:   begin res = sub_w[DATA_W-1:0]; c_out = sub_w[DATA_W];
                        dc_out = sub_n[4];     upd = '{z: 1'b1, c: 1'b1, dc: 1'b1}; end
         K_ADD:   begin res = add_w[DATA_W-1:0]; c_out = add_w[DATA_W];
                        dc_out = add_n[4];     upd = '{z: 1'b1, c: 1'b1, dc: 1'b1}; end
         K_DEC:   begin res = r_val - ONE;     upd.z = 1'b1; end
         K_OR:    begin res = a_val | r_val;   upd.z = 1'b1; end
         K_AND:   begin res = a_val & r_val;   upd.z = 1'b1; end
         K_XOR:   begin res = a_val ^ r_val;   upd.z = 1'b1; end
         K_MOV:   begin res = r_val;           upd.z = 1'b1; end
         K_COM:   begin res = ~r_val;          upd.z = 1'b1; end
         K_INC:   begin res = r_val + ONE;     upd.z = 1'b1; end
         K_DJZ:   begin res = r_val - ONE;     skip_req = (r_val == ONE); end
         K_RRC:   begin res = {c_in, r_val[DATA_W-1:1]}; c_out = r_val[0]; upd.c = 1'b1; end
         default: res = '0;
      endcase
   end

   assign z_out = (res == '0);

endmodule

// File: rtl/ex_regfile.sv
module ex_regfile
   import ex_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int REG_AW       = 6,
   parameter int COMMON_DEPTH = 32,
   parameter int BANK_BITS    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic              we,
   input  logic [REG_AW-1:0] waddr,
   input  logic [DATA_W-1:0] wdata
);

   localparam int DEPTH        = 1 << REG_AW;
   localparam int BANKED_DEPTH = DEPTH - COMMON_DEPTH;
   localparam int NBANK        = 1 << BANK_BITS;
   localparam int CAW          = $clog2(COMMON_DEPTH);
   localparam int LAW          = $clog2(BANKED_DEPTH);
   localparam logic [REG_AW-1:0] COMMON_LIM = REG_AW'(COMMON_DEPTH);

   if (COMMON_DEPTH <= BANK_ADDR || COMMON_DEPTH >= DEPTH) begin : g_bad_depth
      $error("ex_regfile: COMMON_DEPTH must cover the bank register and leave a banked area");
   end
   if (BANK_BITS > DATA_W) begin : g_bad_bank
      $error("ex_regfile: BANK_BITS exceeds the register width");
   end

   logic [DATA_W-1:0] com_q [COMMON_DEPTH];
   logic              w_com, r_com;
   logic [CAW-1:0]    w_ci, r_ci;
   logic [LAW-1:0]    w_li, r_li;
   logic [DATA_W-1:0] ban_rd;

   assign w_com = (waddr < COMMON_LIM);
   assign r_com = (raddr < COMMON_LIM);
   assign w_ci  = CAW'(waddr);
   assign r_ci  = CAW'(raddr);
   assign w_li  = LAW'(waddr - COMMON_LIM);
   assign r_li  = LAW'(raddr - COMMON_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < COMMON_DEPTH; i++) com_q[i] <= '0;
      end else if (we && w_com) begin
         com_q[w_ci] <= wdata;
      end
   end

   if (BANK_BITS > 0) begin : g_banked
      logic [DATA_W-1:0]    mem_q [NBANK][BANKED_DEPTH];
      logic [BANK_BITS-1:0] sel;
      assign sel = com_q[BANK_ADDR][DATA_W-1 -: BANK_BITS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int b = 0; b < NBANK; b++)
               for (int i = 0; i < BANKED_DEPTH; i++) mem_q[b][i] <= '0;
         end else if (we && !w_com) begin
            mem_q[sel][w_li] <= wdata;
         end
      end
      assign ban_rd = mem_q[sel][r_li];
   end else begin : g_flat
      logic [DATA_W-1:0] mem_q [BANKED_DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < BANKED_DEPTH; i++) mem_q[i] <= '0;
         end else if (we && !w_com) begin
            mem_q[w_li] <= wdata;
         end
      end
      assign ban_rd = mem_q[r_li];
   end

   assign rdata = r_com ? com_q[r_ci] : ban_rd;

endmodule

// File: rtl/ex_regalu_unit.sv
module ex_regalu_unit
   import ex_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int REG_AW       = 6,
   parameter int INSTR_W      = 13,
   parameter int COMMON_DEPTH = 32,
   parameter int BANK_BITS    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ins_valid,
   input  logic [INSTR_W-1:0] ins_word,
   output logic               ins_ready,
   output logic [DATA_W-1:0]  acc_o,
   output logic               flag_z,
   output logic               flag_c,
   output logic               flag_dc,
   output logic               skip_o
);

   localparam int OP_W = INSTR_W - REG_AW;
   localparam logic [REG_AW-1:0] STAT_A = REG_AW'(STAT_ADDR);

   if (DATA_W != 8) begin : g_bad_data
      $error("ex_regalu_unit: nibble flags assume an 8-bit datapath");
   end
   if (OP_W != 7) begin : g_bad_op
      $error("ex_regalu_unit: INSTR_W must equal REG_AW + 7");
   end

   logic [DATA_W-1:0] acc_q, stat_q, stat_n;
   logic [DATA_W-1:0] rf_rd, r_val, res;
   logic              skip_q, fire, dest_r, writes, to_stat;
   logic              z_v, c_v, dc_v, skip_req;
   logic [6:0]        op;
   logic [REG_AW-1:0] addr;
   kind_e             kind;
   upd_t              upd;

   assign op     = ins_word[INSTR_W-1:REG_AW];
   assign addr   = ins_word[REG_AW-1:0];
   assign kind   = op_kind(op);
   assign dest_r = op[0];
   assign fire   = ins_valid && ins_ready;
   assign writes = fire && (kind != K_NONE);
   assign to_stat = (addr == STAT_A);
   assign r_val  = to_stat ? stat_q : rf_rd;

   ex_regfile #(
      .DATA_W(DATA_W), .REG_AW(REG_AW),
      .COMMON_DEPTH(COMMON_DEPTH), .BANK_BITS(BANK_BITS)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .raddr(addr), .rdata(rf_rd),
      .we(writes && dest_r && !to_stat), .waddr(addr), .wdata(res)
   );

   ex_alu #(.DATA_W(DATA_W)) u_alu (
      .kind(kind), .a_val(acc_q), .r_val(r_val), .c_in(stat_q[FLG_C]),
      .res(res), .z_out(z_v), .c_out(c_v), .dc_out(dc_v),
      .upd(upd), .skip_req(skip_req)
   );

   // Status write first, then the instruction's own flag updates on top.
   always_comb begin
      stat_n = stat_q;
      if (writes && dest_r && to_stat) stat_n = res;
      if (fire) begin
         if (upd.z)  stat_n[FLG_Z]  = z_v;
         if (upd.c)  stat_n[FLG_C]  = c_v;
         if (upd.dc) stat_n[FLG_DC] = dc_v;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         stat_q <= '0;
         skip_q <= 1'b0;
      end else begin
         stat_q <= stat_n;
         skip_q <= fire && skip_req;
         if (writes && !dest_r) acc_q <= res;
      end
   end

   assign ins_ready = !skip_q;
   assign skip_o    = skip_q;
   assign acc_o     = acc_q;
   assign flag_z    = stat_q[FLG_Z];
   assign flag_c    = stat_q[FLG_C];
   assign flag_dc   = stat_q[FLG_DC];

endmodule

module ex_regalu_chk #(
   parameter int DATA_W  = 8,
   parameter int REG_AW  = 6,
   parameter int INSTR_W = 13
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ins_valid,
   input logic [INSTR_W-1:0] ins_word,
   input logic               ins_ready,
   input logic [DATA_W-1:0]  acc_o,
   input logic               flag_z,
   input logic               flag_c,
   input logic               flag_dc,
   input logic               skip_o
);

   logic       acc_fire;
   logic [6:0] opw;
   logic       stat_tgt;

   assign acc_fire = ins_valid && ins_ready;
   assign opw      = ins_word[INSTR_W-1:REG_AW];
   assign stat_tgt = (ins_word[REG_AW-1:0] == REG_AW'(3));

   // R5
   clra_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && opw == 7'd2 |=> acc_o == '0 && flag_z);

   // R2
   dest_reg_keeps_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && opw[0] |=> $stable(acc_o));

   // R6
   movra_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && opw == 7'd1 && !stat_tgt |=> $stable({flag_z, flag_c, flag_dc}));

   // R7
   skip_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |-> $past(acc_fire && opw[6:1] == 6'd11));

   // R7
   skip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |=> !skip_o);

   // R7
   skip_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_o |=> $stable(acc_o) && $stable({flag_z, flag_c, flag_dc}));

   // R8
   rrc_keeps_z_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && opw[6:1] == 6'd12 && !stat_tgt |=> $stable({flag_z, flag_dc}));

endmodule

bind ex_regalu_unit ex_regalu_chk #(
   .DATA_W(DATA_W), .REG_AW(REG_AW), .INSTR_W(INSTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
   .ins_ready(ins_ready), .acc_o(acc_o), .flag_z(flag_z), .flag_c(flag_c),
   .flag_dc(flag_dc), .skip_o(skip_o)
);

// File: tb/tb_ex_regalu_unit.sv
`timescale 1ns/1ps
module tb_ex_regalu_unit;

   localparam logic [6:0] OP_NOP = 7'd0,  OP_MOVRA = 7'd1, OP_CLRA = 7'd2, OP_CLR = 7'd3;
   localparam logic [6:0] OP_SUBA = 7'd4, OP_SUBR = 7'd5, OP_DECA = 7'd6;
   localparam logic [6:0] OP_ORA = 7'd8,  OP_ANDA = 7'd10, OP_XORR = 7'd13;
   localparam logic [6:0] OP_ADDA = 7'd14, OP_ADDR = 7'd15, OP_MOVA = 7'd16;
   localparam logic [6:0] OP_COMA = 7'd18, OP_INCR = 7'd21, OP_DJZA = 7'd22, OP_DJZR = 7'd23;
   localparam logic [6:0] OP_RRCA = 7'd24, OP_RRCR = 7'd25;
   localparam logic [5:0] TMP = 6'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_valid = 1'b0;
   logic [12:0] ins_word = '0;
   logic        ins_ready, flag_z, flag_c, flag_dc, skip_o;
   logic [7:0]  acc_o;
   int          total = 0;
   int          bad = 0;
   logic [7:0]  rd;

   always #2 clk = ~clk;

   ex_regalu_unit dut (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .ins_ready(ins_ready), .acc_o(acc_o), .flag_z(flag_z), .flag_c(flag_c),
      .flag_dc(flag_dc), .skip_o(skip_o)
   );

   function automatic logic [12:0] enc(input logic [6:0] op, input logic [5:0] ad);
      return {op, ad};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // flags packed as {z, dc, c}
   task automatic chk_flags(input string tag, input logic z, input logic dc, input logic c);
      chk(tag, {5'b0, flag_z, flag_dc, flag_c}, {5'b0, z, dc, c});
   endtask

   task automatic issue(input logic [12:0] w);
      @(negedge clk);
      ins_valid = 1'b1;
      ins_word  = w;
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   task automatic set_reg(input logic [5:0] ad, input logic [7:0] val);
      issue(enc(OP_CLR, ad));
      for (int i = 7; i >= 0; i--) begin
         issue(enc(OP_MOVA, ad));
         issue(enc(OP_ADDR, ad));
         if (val[i]) issue(enc(OP_INCR, ad));
      end
   endtask

   task automatic set_a(input logic [7:0] val);
      set_reg(TMP, val);
      issue(enc(OP_MOVA, TMP));
   endtask

   task automatic set_flags(input logic z, input logic dc, input logic c);
      set_a({5'b0, z, dc, c});
      issue(enc(OP_MOVRA, 6'd3));
   endtask

   task automatic get_reg(input logic [5:0] ad, output logic [7:0] v);
      issue(enc(OP_MOVA, ad));
      v = acc_o;
   endtask

   task automatic t_reset;
      chk("R1 acc", acc_o, 8'h00);
      chk_flags("R1 flags", 1'b0, 1'b0, 1'b0);
      chk("R1 ready/skip", {6'b0, ins_ready, skip_o}, 8'h02);
      get_reg(6'h25, rd);
      chk("R1 banked reg", rd, 8'h00);
   endtask

   task automatic t_add;
      set_reg(6'h11, 8'h3A);
      set_a(8'hC9);
      issue(enc(OP_ADDA, 6'h11));
      chk("R4 add to A", acc_o, 8'h03);
      chk_flags("R4 add flags", 1'b0, 1'b1, 1'b1);
      set_reg(6'h12, 8'h80);
      set_a(8'h80);
      issue(enc(OP_ADDR, 6'h12));
      chk("R2 add to R keeps A", acc_o, 8'h80);
      chk_flags("R4 add zero flags", 1'b1, 1'b0, 1'b1);
      get_reg(6'h12, rd);
      chk("R4 add to R value", rd, 8'h00);
   endtask

   task automatic t_sub;
      set_reg(6'h11, 8'h20);
      set_a(8'h21);
      issue(enc(OP_SUBA, 6'h11));
      chk("R3 sub borrow", acc_o, 8'hFF);
      chk_flags("R3 sub borrow flags", 1'b0, 1'b0, 1'b0);
      set_reg(6'h11, 8'h31);
      set_a(8'h12);
      issue(enc(OP_SUBA, 6'h11));
      chk("R3 sub nibble", acc_o, 8'h1F);
      chk_flags("R3 sub nibble flags", 1'b0, 1'b0, 1'b1);
      set_reg(6'h12, 8'h55);
      set_a(8'h55);
      issue(enc(OP_SUBR, 6'h12));
      chk("R2 sub to R keeps A", acc_o, 8'h55);
      chk_flags("R3 sub equal flags", 1'b1, 1'b1, 1'b1);
      get_reg(6'h12, rd);
      chk("R3 sub to R value", rd, 8'h00);
   endtask

   task automatic t_logic;
      set_reg(6'h13, 8'hF0);
      set_reg(6'h14, 8'h0F);
      set_flags(1'b0, 1'b1, 1'b1);
      issue(enc(OP_MOVA, 6'h14));
      issue(enc(OP_ANDA, 6'h13));
      chk("R5 and", acc_o, 8'h00);
      chk_flags("R5 and flags", 1'b1, 1'b1, 1'b1);
      issue(enc(OP_MOVA, 6'h14));
      issue(enc(OP_ORA, 6'h13));
      chk("R5 or", acc_o, 8'hFF);
      chk_flags("R5 or flags", 1'b0, 1'b1, 1'b1);
      issue(enc(OP_XORR, 6'h13));
      chk("R2 xor to R keeps A", acc_o, 8'hFF);
      issue(enc(OP_COMA, 6'h14));
      chk("R5 complement", acc_o, 8'hF0);
      get_reg(6'h13, rd);
      chk("R5 xor to R value", rd, 8'h0F);
      set_reg(6'h15, 8'hFF);
      set_flags(1'b0, 1'b1, 1'b0);
      issue(enc(OP_INCR, 6'h15));
      chk_flags("R5 inc wrap flags", 1'b1, 1'b1, 1'b0);
      issue(enc(OP_DECA, 6'h15));
      chk("R5 dec wrap", acc_o, 8'hFF);
      chk_flags("R5 dec flags", 1'b0, 1'b1, 1'b0);
      issue(enc(OP_CLRA, 6'h00));
      chk("R5 clear A", acc_o, 8'h00);
      chk_flags("R5 clear A flags", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_movra;
      set_flags(1'b1, 1'b0, 1'b1);
      issue(enc(OP_MOVRA, 6'h16));
      chk_flags("R6 move to R flags", 1'b1, 1'b0, 1'b1);
      get_reg(6'h16, rd);
      chk("R6 move to R value", rd, 8'h05);
   endtask

   task automatic t_djz;
      set_reg(6'h17, 8'h02);
      set_flags(1'b1, 1'b1, 1'b1);
      issue(enc(OP_DJZA, 6'h17));
      chk("R7 djz to A", acc_o, 8'h01);
      chk("R7 no skip", {6'b0, ins_ready, skip_o}, 8'h02);
      issue(enc(OP_DJZR, 6'h17));
      chk("R7 no skip at one", {6'b0, ins_ready, skip_o}, 8'h02);
      issue(enc(OP_DJZR, 6'h17));
      chk("R7 skip raised", {6'b0, ins_ready, skip_o}, 8'h01);
      chk_flags("R7 djz flags", 1'b1, 1'b1, 1'b1);
      ins_valid = 1'b1;
      ins_word  = enc(OP_CLRA, 6'h00);
      @(negedge clk);
      ins_valid = 1'b0;
      chk("R7 skipped slot discarded", acc_o, 8'h01);
      chk("R7 skip ends", {6'b0, ins_ready, skip_o}, 8'h02);
      get_reg(6'h17, rd);
      chk("R7 djz to R value", rd, 8'h00);
   endtask

   task automatic t_rrc;
      set_reg(6'h18, 8'h02);
      set_flags(1'b1, 1'b1, 1'b1);
      issue(enc(OP_RRCA, 6'h18));
      chk("R8 rotate into A", acc_o, 8'h81);
      chk_flags("R8 rotate flags", 1'b1, 1'b1, 1'b0);
      issue(enc(OP_RRCR, 6'h18));
      get_reg(6'h18, rd);
      chk("R8 rotate R value", rd, 8'h01);
   endtask

   task automatic t_bank;
      set_reg(6'h20, 8'h11);
      set_reg(6'h04, 8'h40);
      set_reg(6'h20, 8'h22);
      set_reg(6'h3F, 8'h33);
      get_reg(6'h20, rd);
      chk("R9 bank1 value", rd, 8'h22);
      set_reg(6'h1F, 8'h44);
      set_reg(6'h04, 8'h00);
      get_reg(6'h20, rd);
      chk("R9 bank0 kept", rd, 8'h11);
      get_reg(6'h3F, rd);
      chk("R9 bank0 top untouched", rd, 8'h00);
      set_reg(6'h04, 8'hC0);
      get_reg(6'h1F, rd);
      chk("R9 common shared", rd, 8'h44);
      set_reg(6'h04, 8'h00);
   endtask

   task automatic t_status;
      set_a(8'h06);
      issue(enc(OP_MOVRA, 6'd3));
      chk_flags("R10 status write", 1'b1, 1'b1, 1'b0);
      get_reg(6'd3, rd);
      chk("R10 status read", rd, 8'h06);
      issue(enc(OP_CLR, 6'd3));
      chk_flags("R10 clear overridden by Z", 1'b1, 1'b0, 1'b0);
      issue(enc(OP_ADDR, 6'd3));
      get_reg(6'd3, rd);
      chk("R10 add into status", rd, 8'h08);
   endtask

   task automatic t_unused;
      set_flags(1'b0, 1'b1, 1'b1);
      issue(enc(OP_NOP, 6'h05));
      issue(enc(7'h30, 6'h11));
      issue(enc(7'h7F, 6'h3F));
      chk("R2 unused codes keep A", acc_o, 8'h03);
      chk_flags("R2 unused codes keep flags", 1'b0, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_movra();
      t_djz();
      t_rrc();
      t_bank();
      t_status();
      t_unused();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule